// File: doc/BRIEF.md
# Event Profiling and Trace Monitor

This unit sits beside an instrumented design and watches it without disturbing it. It counts cycles in which each of several event lines is high. It keeps a per-state residency count for one monitored state vector, and it records timestamped samples of a watched signal whenever a programmable comparison fires. All results share one free-running cycle counter. They are read back one word at a time through a request/response port, with a fixed latency of one cycle.

A host controls measurement with three pulse inputs: start, stop and clear. It sets the trigger through static configuration inputs: the reference value, the comparison kind, edge or level mode, and wrap mode. Profile counters are registers. State residency counts live in a small synchronous-read RAM updated by read-modify-write, with forwarding for back-to-back hits on the same state. A clear, and the reset that precedes operation, zeroes that RAM one entry per cycle while a busy flag is high.

Top module: `event_trace_monitor`

## Requirements
- R1: While measuring (running, not busy, no clear this cycle), each profile counter rises by one for every cycle its event input is high, and it never changes otherwise except on clear.
- R2: Every counter (profile and state) saturates at its all-ones value; counter i's saturation flag is readable in the statistics word.
- R3: Each measuring cycle adds one to the residency count of the current state, including runs of the same state on consecutive cycles.
- R4: The cycle counter starts at zero after reset or clear and advances every cycle; each trace entry stores its value in the cycle of the event, above the sampled data.
- R5: The trigger compares the watched signal, unsigned, against the reference: op 0 equal, 1 not equal, 2 greater than, 3 less than.
- R6: In level mode every matching measuring cycle records an entry; in edge mode only a cycle whose comparison is true after a false cycle does so.
- R7: The trace buffer holds 2^TRACE_AW entries written in slot order from 0. Without wrap, a trigger on a full buffer writes nothing and sets a sticky overflow flag. With wrap, writing continues at slot 0 and the entry count stays at full.
- R8: A start pulse enables measurement from the next cycle and a stop pulse disables it; if both arrive together, stop wins.
- R9: Reset or a clear pulse zeroes counters, residency counts, cycle counter, trace count, pointer and overflow. Busy is then high for 2^STATE_W cycles, and nothing is measured while it is high.
- R10: A request returns its word with respValid in the next cycle. Select 0 is the profile counter, 1 the state count, 2 the trace slot as {timestamp, data}, and 3 the statistics word. In that word, bits [TRACE_AW:0] hold the entry count, the next bit is overflow, and the saturation flags come above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | NUM_EVT | Event lines for the profile counters |
| fsmState | input | STATE_W | Monitored state vector |
| watchSig | input | SIG_W | Watched signal for trigger and trace data |
| ctrlStart | input | 1 | Start measurement pulse |
| ctrlStop | input | 1 | Stop measurement pulse |
| ctrlClear | input | 1 | Clear-all pulse |
| cfgRef | input | SIG_W | Trigger reference value |
| cfgOp | input | 2 | Comparison kind |
| cfgEdge | input | 1 | 1 = edge mode, 0 = level mode |
| cfgWrap | input | 1 | 1 = trace buffer wraps when full |
| reqValid | input | 1 | Read request strobe |
| reqSel | input | 2 | Read space select |
| reqIdx | input | IDX_W | Index within the space |
| running | output | 1 | Measurement enabled |
| busy | output | 1 | RAM clear in progress |
| overflow | output | 1 | Sticky trace overflow |
| respValid | output | 1 | Response valid |
| respData | output | TS_W+SIG_W | Response word |

## Verification
On every cycle, the assertions check the single-step behaviour of the counters and the cycle counter, saturation holding, that nothing moves while idle, the forwarding rule for repeated states, edge-mode spacing, the trace bound and overflow stickiness, the length of the busy window and the response latency. Only the bench scenarios can show that the accumulated values are right: the residency totals after long same-state runs, the trace slot contents under each comparison kind and mode, and the wrap and overflow outcomes. A behavioural model supplies the expected values, and the bench compares them against read-backs and the status outputs.

// File: rtl/etm_pkg.sv
package etm_pkg;
  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_GT = 2'd2,
    CMP_LT = 2'd3
  } cmpOp_e;

  typedef enum logic [1:0] {
    SEL_PROF  = 2'd0,
    SEL_STATE = 2'd1,
    SEL_TRACE = 2'd2,
    SEL_STAT  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic active;    // measuring this cycle
    logic clearNow;  // clear pulse this cycle
    logic clrWrite;  // RAM clear sequencer writing
  } ctrlStrb_t;
endpackage

// File: rtl/etm_ctrl.sv
module etm_ctrl
  import etm_pkg::*;
#(
  parameter int STATE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlStart,
  input  logic               ctrlStop,
  input  logic               ctrlClear,
  output ctrlStrb_t          strb,
  output logic [STATE_W-1:0] clrIdx,
  output logic               running,
  output logic               busy
);
  localparam int STATES = 1 << STATE_W;
  localparam logic [STATE_W-1:0] LAST_IDX = STATE_W'(STATES - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      busy    <= 1'b1;
      clrIdx  <= '0;
    end else begin
      if (ctrlStop)       running <= 1'b0;
      else if (ctrlStart) running <= 1'b1;

      if (ctrlClear) begin
        busy   <= 1'b1;
        clrIdx <= '0;
      end else if (busy) begin
        if (clrIdx == LAST_IDX) busy <= 1'b0;
        clrIdx <= clrIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.active   = running && !busy && !ctrlClear;
    strb.clearNow = ctrlClear;
    strb.clrWrite = busy;
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && clrIdx != LAST_IDX && !ctrlClear |=> busy);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && clrIdx == LAST_IDX && !ctrlClear |=> !busy);
  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStop |=> !running);
endmodule

// File: rtl/etm_dp.sv
module etm_dp
  import etm_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int CNT_W    = 16,
  parameter int STATE_W  = 3,
  parameter int SIG_W    = 8,
  parameter int TS_W     = 16,
  parameter int TRACE_AW = 3,
  parameter int IDX_W    = 3,
  parameter int RESP_W   = TS_W + SIG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [STATE_W-1:0] clrIdx,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [STATE_W-1:0] fsmState,
  input  logic [SIG_W-1:0]   watchSig,
  input  logic [SIG_W-1:0]   cfgRef,
  input  logic [1:0]         cfgOp,
  input  logic               cfgEdge,
  input  logic               cfgWrap,
  input  logic               reqValid,
  input  logic [1:0]         reqSel,
  input  logic [IDX_W-1:0]   reqIdx,
  output logic               overflow,
  output logic               respValid,
  output logic [RESP_W-1:0]  respData
);
  localparam int STATES = 1 << STATE_W;
  localparam int DEPTH  = 1 << TRACE_AW;
  localparam int EVT_AW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int TE_W   = TS_W + SIG_W;
  localparam logic [TRACE_AW:0] FULL_CNT = (TRACE_AW + 1)'(DEPTH);

  // ---------------- profile counters ----------------
  logic [CNT_W-1:0]   profCnt [NUM_EVT];
  logic [NUM_EVT-1:0] satFlag;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_prof
    always_ff @(posedge clk) begin
      if (!rstN || strb.clearNow) profCnt[g] <= '0;
      else if (strb.active && evtIn[g] && !(&profCnt[g])) profCnt[g] <= profCnt[g] + 1'b1;
    end
    assign satFlag[g] = &profCnt[g];

    // R1
    prof_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.clearNow && !(&profCnt[g]) |=>
        (profCnt[g] == $past(profCnt[g]) || profCnt[g] == $past(profCnt[g]) + 1'b1));
    // R1
    prof_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.active && !strb.clearNow |=> $stable(profCnt[g]));
    // R2
    prof_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
      (&profCnt[g]) && !strb.clearNow |=> (&profCnt[g]));
  end

  // ---------------- cycle counter ----------------
  logic [TS_W-1:0] cycCnt;
  always_ff @(posedge clk) begin
    if (!rstN || strb.clearNow) cycCnt <= '0;
    else                        cycCnt <= cycCnt + 1'b1;
  end

  // R4
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearNow |=> cycCnt == $past(cycCnt) + 1'b1);

  // ---------------- state residency RAM ----------------
  logic [CNT_W-1:0]   stMem [STATES];
  logic [CNT_W-1:0]   rmwRd, hostStRd, baseVal, incVal, lastData;
  logic [STATE_W-1:0] pAddr, lastAddr;
  logic               pValid, lastValid;

  always_comb begin
    baseVal = (lastValid && lastAddr == pAddr) ? lastData : rmwRd;
    incVal  = (&baseVal) ? baseVal : baseVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    rmwRd    <= stMem[fsmState];
    hostStRd <= stMem[reqIdx[STATE_W-1:0]];
    if (strb.clrWrite)  stMem[clrIdx] <= '0;
    else if (pValid)    stMem[pAddr]  <= incVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pValid    <= 1'b0;
      pAddr     <= '0;
      lastValid <= 1'b0;
      lastAddr  <= '0;
      lastData  <= '0;
    end else begin
      pValid    <= strb.active;
      pAddr     <= fsmState;
      lastValid <= pValid && !strb.clrWrite;
      lastAddr  <= pAddr;
      lastData  <= incVal;
    end
  end

  // R3
  rmw_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    pValid && lastValid && pAddr == lastAddr |->
      (incVal == lastData + 1'b1 || (&lastData)));

  // ---------------- trigger ----------------
  logic cmpHit, cmpPrev, fire, take;
  always_comb begin
    unique case (cmpOp_e'(cfgOp))
      CMP_EQ:  cmpHit = (watchSig == cfgRef);
      CMP_NE:  cmpHit = (watchSig != cfgRef);
      CMP_GT:  cmpHit = (watchSig >  cfgRef);
      default: cmpHit = (watchSig <  cfgRef);
    endcase
    fire = cfgEdge ? (cmpHit && !cmpPrev) : cmpHit;
    take = strb.active && fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmpPrev <= 1'b0;
    else       cmpPrev <= cmpHit;
  end

  // R6
  edge_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgEdge && take |=> !(cfgEdge && take));

  // ---------------- trace buffer ----------------
  logic [TE_W-1:0]     trMem [DEPTH];
  logic [TE_W-1:0]     trRd;
  logic [TRACE_AW-1:0] wrPtr;
  logic [TRACE_AW:0]   trCnt;
  logic                full, trWr;

  assign full = (trCnt == FULL_CNT);
  assign trWr = take && (!full || cfgWrap);

  always_ff @(posedge clk) begin
    if (trWr) trMem[wrPtr] <= {cycCnt, watchSig};
    trRd <= trMem[reqIdx[TRACE_AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearNow) begin
      wrPtr    <= '0;
      trCnt    <= '0;
      overflow <= 1'b0;
    end else if (take) begin
      if (full && !cfgWrap) begin
        overflow <= 1'b1;
      end else begin
        wrPtr <= wrPtr + 1'b1;
        if (!full) trCnt <= trCnt + 1'b1;
      end
    end
  end

  // R7
  trace_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    trCnt <= FULL_CNT);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !strb.clearNow |=> overflow);
  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && !cfgWrap && !strb.clearNow |=> $stable(wrPtr));

  // ---------------- readout ----------------
  logic [1:0]        rSel;
  logic [RESP_W-1:0] regWord, regPick;

  always_comb begin
    regPick = '0;
    if (rdSel_e'(reqSel) == SEL_PROF) begin
      if (32'(reqIdx) < NUM_EVT) regPick = RESP_W'(profCnt[reqIdx[EVT_AW-1:0]]);
    end else begin
      regPick = RESP_W'({satFlag, overflow, trCnt});
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      rSel      <= '0;
      regWord   <= '0;
    end else begin
      respValid <= reqValid;
      rSel      <= reqSel;
      regWord   <= regPick;
    end
  end

  always_comb begin
    unique case (rdSel_e'(rSel))
      SEL_STATE: respData = RESP_W'(hostStRd);
      SEL_TRACE: respData = RESP_W'(trRd);
      default:   respData = regWord;
    endcase
  end

  // R10
  resp_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  // R10
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
endmodule

// File: rtl/event_trace_monitor.sv
module event_trace_monitor
  import etm_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int CNT_W    = 16,
  parameter int STATE_W  = 3,
  parameter int SIG_W    = 8,
  parameter int TS_W     = 16,
  parameter int TRACE_AW = 3,
  localparam int EVT_AW  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
  localparam int IDX_A   = (STATE_W > TRACE_AW) ? STATE_W : TRACE_AW,
  localparam int IDX_W   = (IDX_A > EVT_AW) ? IDX_A : EVT_AW,
  localparam int RESP_W  = TS_W + SIG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [STATE_W-1:0] fsmState,
  input  logic [SIG_W-1:0]   watchSig,
  input  logic               ctrlStart,
  input  logic               ctrlStop,
  input  logic               ctrlClear,
  input  logic [SIG_W-1:0]   cfgRef,
  input  logic [1:0]         cfgOp,
  input  logic               cfgEdge,
  input  logic               cfgWrap,
  input  logic               reqValid,
  input  logic [1:0]         reqSel,
  input  logic [IDX_W-1:0]   reqIdx,
  output logic               running,
  output logic               busy,
  output logic               overflow,
  output logic               respValid,
  output logic [RESP_W-1:0]  respData
);
  ctrlStrb_t          strb;
  logic [STATE_W-1:0] clrIdx;

  etm_ctrl #(.STATE_W(STATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlStart(ctrlStart), .ctrlStop(ctrlStop), .ctrlClear(ctrlClear),
    .strb(strb), .clrIdx(clrIdx), .running(running), .busy(busy)
  );

  etm_dp #(
    .NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .STATE_W(STATE_W), .SIG_W(SIG_W),
    .TS_W(TS_W), .TRACE_AW(TRACE_AW), .IDX_W(IDX_W), .RESP_W(RESP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .clrIdx(clrIdx),
    .evtIn(evtIn), .fsmState(fsmState), .watchSig(watchSig),
    .cfgRef(cfgRef), .cfgOp(cfgOp), .cfgEdge(cfgEdge), .cfgWrap(cfgWrap),
    .reqValid(reqValid), .reqSel(reqSel), .reqIdx(reqIdx),
    .overflow(overflow), .respValid(respValid), .respData(respData)
  );
endmodule

// File: tb/event_trace_monitor_test.sv
module event_trace_monitor_test;
  localparam int NE = 4, CW = 8, SW = 3, GW = 8, TW = 16, AW = 3;
  localparam int NST = 1 << SW, DEP = 1 << AW, CMAX = (1 << CW) - 1;

  logic clk = 0, rstN = 0;
  logic [NE-1:0] evtIn = '0;
  logic [SW-1:0] fsmState = '0;
  logic [GW-1:0] watchSig = '0, cfgRef = '0;
  logic ctrlStart = 0, ctrlStop = 0, ctrlClear = 0;
  logic [1:0] cfgOp = '0, reqSel = '0;
  logic cfgEdge = 0, cfgWrap = 0, reqValid = 0;
  logic [2:0] reqIdx = '0;
  logic running, busy, overflow, respValid;
  logic [TW+GW-1:0] respData;

  event_trace_monitor #(.NUM_EVT(NE), .CNT_W(CW), .STATE_W(SW), .SIG_W(GW),
                        .TS_W(TW), .TRACE_AW(AW)) uut (.*);

  always #2 clk = ~clk;   // 250 MHz

  int nChk = 0, nFail = 0, cyc = 0;
  int unsigned seed = 32'h1234_5678;

  // ---------------- behavioural reference ----------------
  int mProf[NE], mSt[NST], mTs[DEP], mDat[DEP];
  int mCyc, mTrCnt, mPtr, mBusyLeft;
  bit mRun, mOvf, mPrev;

  always @(posedge clk) begin
    bit act, hit, fire;
    if (!rstN) begin
      foreach (mProf[i]) mProf[i] = 0;
      foreach (mSt[i]) mSt[i] = 0;
      mCyc = 0; mTrCnt = 0; mPtr = 0; mOvf = 0; mRun = 0; mPrev = 0;
      mBusyLeft = NST;
    end else begin
      act = mRun && (mBusyLeft == 0) && !ctrlClear;
      case (cfgOp)
        2'd0: hit = (watchSig == cfgRef);
        2'd1: hit = (watchSig != cfgRef);
        2'd2: hit = (watchSig > cfgRef);
        default: hit = (watchSig < cfgRef);
      endcase
      fire = cfgEdge ? (hit && !mPrev) : hit;
      mPrev = hit;
      if (ctrlClear) begin
        foreach (mProf[i]) mProf[i] = 0;
        foreach (mSt[i]) mSt[i] = 0;
        mTrCnt = 0; mPtr = 0; mOvf = 0;
      end else if (act) begin
        for (int i = 0; i < NE; i++)
          if (evtIn[i] && mProf[i] < CMAX) mProf[i]++;
        if (mSt[fsmState] < CMAX) mSt[fsmState]++;
        if (fire) begin
          if (mTrCnt == DEP && !cfgWrap) mOvf = 1;
          else begin
            mTs[mPtr] = mCyc; mDat[mPtr] = watchSig;
            mPtr = (mPtr + 1) % DEP;
            if (mTrCnt < DEP) mTrCnt++;
          end
        end
      end
      mCyc = ctrlClear ? 0 : (mCyc + 1) & 16'hFFFF;
      if (ctrlClear) mBusyLeft = NST;
      else if (mBusyLeft > 0) mBusyLeft--;
      if (ctrlStop) mRun = 0;
      else if (ctrlStart) mRun = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // status outputs against the model every cycle
  always @(negedge clk) begin
    if (rstN) begin
      check(running == mRun, "R8 running", running, mRun);
      check(busy == (mBusyLeft > 0), "R9 busy", busy, mBusyLeft > 0);
      check(overflow == mOvf, "R7 overflow", overflow, mOvf);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic int unsigned nextRnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic runCycles(input int n, input bit satMode);
    for (int k = 0; k < n; k++) begin
      int unsigned r;
      @(negedge clk);
      r = nextRnd();
      evtIn = satMode ? (4'b0001 | 4'(r)) : 4'(r);
      if (satMode) fsmState = 3'd2;
      else if (r[7:6] == 2'b00) fsmState = 3'(r >> 10);
      watchSig = 8'(r[14:12]);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ctrlStart = 1;
      1: ctrlStop = 1;
      2: ctrlClear = 1;
      default: begin ctrlStart = 1; ctrlStop = 1; end
    endcase
    @(negedge clk);
    ctrlStart = 0; ctrlStop = 0; ctrlClear = 0;
  endtask

  task automatic readWord(input int sel, input int idx, input longint exp, input string tag);
    @(negedge clk);
    reqValid = 1; reqSel = 2'(sel); reqIdx = 3'(idx);
    @(negedge clk);
    reqValid = 0;
    check(respValid == 1'b1, "R10 respValid", respValid, 1);
    check(respData == (TW+GW)'(exp), tag, respData, exp);
  endtask

  task automatic readAll();
    int stat;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NE; i++) readWord(0, i, mProf[i], "R1 R2 profile counter");
    for (int s = 0; s < NST; s++) readWord(1, s, mSt[s], "R3 state residency");
    for (int k = 0; k < mTrCnt; k++)
      readWord(2, k, (longint'(mTs[k]) << GW) | mDat[k], "R4 R5 R6 R7 trace entry");
    stat = mTrCnt | (int'(mOvf) << (AW + 1));
    for (int i = 0; i < NE; i++) if (mProf[i] == CMAX) stat |= 1 << (AW + 2 + i);
    readWord(3, 0, stat, "R2 R7 R10 statistics");
  endtask

  task automatic setup(input int op, input int ref_, input bit edg, input bit wrp);
    @(negedge clk);
    cfgOp = 2'(op); cfgRef = 8'(ref_); cfgEdge = edg; cfgWrap = wrp;
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(busy == 1'b1, "R9 busy after reset", busy, 1);
    repeat (10) @(negedge clk);
    readAll();                                   // R9 reset state

    setup(0, 5, 0, 0);                           // R5 equal, level
    pulse(0);
    runCycles(40, 0);
    pulse(1);
    readAll();

    pulse(2); repeat (10) @(negedge clk);        // R9 clear
    setup(2, 3, 1, 0);                           // R5 greater, R6 edge
    pulse(0);
    runCycles(60, 0);
    pulse(1);
    readAll();

    pulse(2); repeat (10) @(negedge clk);
    setup(1, 2, 0, 1);                           // R5 not equal, R7 wrap
    pulse(0);
    runCycles(30, 0);
    pulse(1);
    readAll();

    pulse(2); repeat (10) @(negedge clk);
    setup(3, 1, 0, 0);                           // R5 less, R2 saturation, R3 repeats
    pulse(0);
    runCycles(300, 1);
    pulse(1);
    readAll();

    setup(1, 0, 0, 0);                           // R9 clear while running
    pulse(2);
    pulse(0);
    runCycles(25, 0);
    pulse(2);
    runCycles(20, 0);
    pulse(1);
    readAll();

    pulse(3);                                    // R8 start and stop together
    check(running == 1'b0, "R8 stop wins", running, 0);
    runCycles(6, 0);
    readAll();

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule